// File: doc/BRIEF.md
# Frame-Modulated Pixel Intensity Generator

This block decides, for every pixel in a group, whether that pixel is lit in the current multiplex cycle. Brightness is set by frame modulation. A 12-step phase counter selects one position in a repeating on/off pattern, and each pixel's 2-bit code selects which pattern applies to it. The two middle codes follow one of two laws. The arithmetic law gives two thirds and one third brightness. The geometric law gives one half and one quarter brightness.

A scan controller pulses the advance strobe once per multiplex cycle and presents the codes of the pixels being driven. It reads back one enable bit per pixel. The law select is latched only when the phase counter wraps, so a single pattern period never mixes the two laws. A one-bit mode lets the same block serve images with one bit per pixel.

Top module: `fm_intensity_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase returns to 0 and the active law becomes arithmetic. Both hold directly after reset.
- R2: `phase` advances by one on each clock edge where `adv` is high, and wraps from 11 to 0. It holds its value when `adv` is low, and it never exceeds 11.
- R3: In two-bit mode (`dual_bit`=1), code 2'b11 is lit in every phase and code 2'b00 is dark in every phase, under either law.
- R4: Under the arithmetic law, code 2'b10 is lit in every phase except those where phase mod 3 equals 1.
- R5: Under the arithmetic law, code 2'b01 is lit only in phases where phase mod 3 equals 1.
- R6: Under the geometric law, code 2'b10 is lit only in even phases.
- R7: Under the geometric law, code 2'b01 is lit only in phases 1, 5 and 9.
- R8: `geo_sel` (1 = geometric, 0 = arithmetic) is captured only on an advance that wraps the phase from 11 to 0. The new law applies from phase 0 onward. A change at any other time has no effect until the next wrap.
- R9: In one-bit mode (`dual_bit`=0), a pixel is lit in every phase when its upper code bit is 1 and dark when it is 0. Its lower code bit has no effect.
- R10: Pixel i uses only code bits [2i+1:2i]. Each pixel's enable is independent of the codes of the other pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Multiplex-cycle advance strobe |
| geo_sel | input | 1 | Law request: 1 geometric, 0 arithmetic |
| dual_bit | input | 1 | 1: two-bit codes, 0: one bit per pixel (upper bit) |
| pix_code | input | 2*NUM_PIX | Pixel codes, pixel i in bits [2i+1:2i] |
| pix_en | output | NUM_PIX | Per-pixel enable for the current phase |
| phase | output | 4 | Current multiplex phase, 0 to 11 |

## Verification
A phase counter that slips, skips or fails to wrap shows up first on `phase`. It also shows up on the enables of mid-level codes within the same cycle, because their patterns are not shift-invariant. A law register that updates outside the wrap point changes the pattern of code 2'b10 or 2'b01 in the cycle that follows. Under the arithmetic law that is visible within three phases, and it is checked across a deliberate mid-period change of `geo_sel`. A wrong entry in a pattern mask appears on the affected pixel in the one phase it covers, so every phase of both laws is stepped through with all four codes present.

// File: rtl/fm_pkg.sv
// Package: shared constants, types and pattern-mask builders for the
// frame-modulated intensity generator. Assumes a 12-phase modulation period.
package fm_pkg;

    localparam int PERIOD = 12;
    localparam int PH_W   = $clog2(PERIOD);
    localparam int PH_SPAN = 1 << PH_W;

    typedef enum logic {
        LAW_ARITH = 1'b0,
        LAW_GEO   = 1'b1
    } law_e;

    typedef logic [1:0] pcode_t;

    // Mask of phases in which the given level is lit under the given law.
    // lvl: 1 = low mid level, 2 = high mid level. Bits past PERIOD are 0.
    function automatic logic [PH_SPAN-1:0] level_mask(input law_e law, input int lvl);
        logic [PH_SPAN-1:0] m;
        m = '0;
        for (int i = 0; i < PERIOD; i++) begin
            if (law == LAW_ARITH) begin
                if (lvl == 2) m[i] = ((i % 3) != 1);
                else          m[i] = ((i % 3) == 1);
            end else begin
                if (lvl == 2) m[i] = ((i % 2) == 0);
                else          m[i] = ((i % 4) == 1);
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/fm_phase_counter.sv
// Phase counter: steps through 0..PERIOD-1 on each advance strobe, wraps to 0.
// Assumes synchronous active-low reset; flags the wrapping advance.
module fm_phase_counter #(
    parameter int PERIOD = fm_pkg::PERIOD,
    localparam int PW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] ph,
    output logic          wrap
);
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    // Wrap happens on an advance taken from the last phase.
    assign wrap = adv && (ph == LAST);

    // Phase register update.
    always_ff @(posedge clk) begin
        if (!rst_n)    ph <= '0;
        else if (wrap) ph <= '0;
        else if (adv)  ph <= ph + PW'(1);
    end
endmodule

// File: rtl/fm_law_reg.sv
// Law register: captures the requested law only at a period wrap so that no
// pattern period mixes the two laws. Resets to the arithmetic law.
module fm_law_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wrap,
    input  logic        geo_sel,
    output fm_pkg::law_e law
);
    // Capture the requested law at the wrap point only.
    always_ff @(posedge clk) begin
        if (!rst_n)    law <= fm_pkg::LAW_ARITH;
        else if (wrap) law <= fm_pkg::law_e'(geo_sel);
    end
endmodule

// File: rtl/fm_level_table.sv
// Level table: for the current phase and law, gives the lit state of each of
// the four code levels. Masks are computed at elaboration from the package.
module fm_level_table #(
    parameter int PERIOD = fm_pkg::PERIOD,
    localparam int PW    = $clog2(PERIOD),
    localparam int SPAN  = 1 << PW
) (
    input  logic [PW-1:0] ph,
    input  fm_pkg::law_e  law,
    output logic [3:0]    lvl_on
);
    localparam logic [SPAN-1:0] ARI_LO = fm_pkg::level_mask(fm_pkg::LAW_ARITH, 1);
    localparam logic [SPAN-1:0] ARI_HI = fm_pkg::level_mask(fm_pkg::LAW_ARITH, 2);
    localparam logic [SPAN-1:0] GEO_LO = fm_pkg::level_mask(fm_pkg::LAW_GEO, 1);
    localparam logic [SPAN-1:0] GEO_HI = fm_pkg::level_mask(fm_pkg::LAW_GEO, 2);

    // Select the mask bit of each mid level for the active law.
    always_comb begin
        lvl_on[0] = 1'b0;
        lvl_on[3] = 1'b1;
        if (law == fm_pkg::LAW_GEO) begin
            lvl_on[1] = GEO_LO[ph];
            lvl_on[2] = GEO_HI[ph];
        end else begin
            lvl_on[1] = ARI_LO[ph];
            lvl_on[2] = ARI_HI[ph];
        end
    end
endmodule

// File: rtl/fm_pixel_gate.sv
// Pixel gate: turns one pixel's code into its enable. In two-bit mode the code
// selects a level; in one-bit mode the upper code bit alone decides.
module fm_pixel_gate (
    input  fm_pkg::pcode_t code,
    input  logic [3:0]     lvl_on,
    input  logic           dual_bit,
    output logic           en
);
    // Level lookup or direct on/off.
    always_comb begin
        if (dual_bit) en = lvl_on[code];
        else          en = code[1];
    end
endmodule

// File: rtl/fm_intensity_gen.sv
// Top: frame-modulated intensity generator for NUM_PIX pixels in parallel.
// Assumes one advance strobe per multiplex cycle; enables are combinational
// from the registered phase/law and the presented codes.
module fm_intensity_gen #(
    parameter int NUM_PIX = 8,
    localparam int PW     = $clog2(fm_pkg::PERIOD)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 geo_sel,
    input  logic                 dual_bit,
    input  logic [2*NUM_PIX-1:0] pix_code,
    output logic [NUM_PIX-1:0]   pix_en,
    output logic [PW-1:0]        phase
);
    logic         wrap;
    fm_pkg::law_e law_q;
    logic [3:0]   lvl_on;

    fm_phase_counter #(.PERIOD(fm_pkg::PERIOD)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .ph   (phase),
        .wrap (wrap)
    );

    fm_law_reg u_law (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .geo_sel(geo_sel),
        .law    (law_q)
    );

    fm_level_table #(.PERIOD(fm_pkg::PERIOD)) u_tab (
        .ph    (phase),
        .law   (law_q),
        .lvl_on(lvl_on)
    );

    // One gate per pixel, each fed only its own code field.
    for (genvar gi = 0; gi < NUM_PIX; gi++) begin : g_pix
        fm_pixel_gate u_gate (
            .code    (pix_code[2*gi +: 2]),
            .lvl_on  (lvl_on),
            .dual_bit(dual_bit),
            .en      (pix_en[gi])
        );
    end
endmodule

// File: rtl/fm_intensity_chk.sv
// Checker: temporal properties of the phase counter, law register and pixel 0
// enable. Bound to the top module below.
module fm_intensity_chk #(
    parameter int NUM_PIX = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 adv,
    input logic                 geo_sel,
    input logic                 dual_bit,
    input logic [2*NUM_PIX-1:0] pix_code,
    input logic [NUM_PIX-1:0]   pix_en,
    input logic [3:0]           phase,
    input logic                 law
);
    a_r1_reset_phase: assert property (@(posedge clk)
        !rst_n |=> (phase == 4'd0) && (law == 1'b0));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(phase));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && phase != 4'd11) |=> phase == $past(phase) + 4'd1);

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && phase == 4'd11) |=> phase == 4'd0);

    a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= 4'd11);

    a_r8_law_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && phase == 4'd11) |=> $stable(law));

    a_r3_full_on: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_bit && pix_code[1:0] == 2'b11) |-> pix_en[0]);

    a_r3_full_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_bit && pix_code[1:0] == 2'b00) |-> !pix_en[0]);

    a_r7_geo_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_bit && law && pix_code[1:0] == 2'b01) |->
        pix_en[0] == (phase == 4'd1 || phase == 4'd5 || phase == 4'd9));

    a_r9_mono: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_bit |-> pix_en[0] == pix_code[1]);
endmodule

bind fm_intensity_gen fm_intensity_chk #(.NUM_PIX(NUM_PIX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .geo_sel (geo_sel),
    .dual_bit(dual_bit),
    .pix_code(pix_code),
    .pix_en  (pix_en),
    .phase   (phase),
    .law     (law_q)
);

// File: tb/tb_fm_intensity_gen.sv
`timescale 1ns/1ps
module tb_fm_intensity_gen;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv = 1'b0;
    logic          geo_sel = 1'b0;
    logic          dual_bit = 1'b1;
    logic [2*NP-1:0] pix_code = '0;
    logic [NP-1:0] pix_en;
    logic [3:0]    phase;

    int checks = 0;
    int errors = 0;
    int m_ph = 0;
    bit m_geo = 1'b0;

    always #2.5 clk = ~clk;

    fm_intensity_gen #(.NUM_PIX(NP)) dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .geo_sel(geo_sel),
        .dual_bit(dual_bit), .pix_code(pix_code), .pix_en(pix_en), .phase(phase)
    );

    function automatic bit ref_en(bit [1:0] c, int ph, bit geo, bit dual);
        if (!dual) return c[1];
        case (c)
            2'b00: return 1'b0;
            2'b11: return 1'b1;
            2'b10: return geo ? (ph % 2 == 0) : (ph % 3 != 1);
            default: return geo ? (ph % 4 == 1) : (ph % 3 == 1);
        endcase
    endfunction

    task automatic check_all(string req);
        checks++;
        if (phase !== 4'(m_ph)) begin
            errors++;
            $display("FAIL %s phase: got %0d exp %0d", req, phase, m_ph);
        end
        for (int i = 0; i < NP; i++) begin
            bit e;
            e = ref_en(pix_code[2*i +: 2], m_ph, m_geo, dual_bit);
            checks++;
            if (pix_en[i] !== e) begin
                errors++;
                $display("FAIL %s pixel %0d phase %0d: got %b exp %b", req, i, m_ph, pix_en[i], e);
            end
        end
    endtask

    task automatic step();
        adv = 1'b1;
        @(posedge clk);
        if (m_ph == 11) begin m_ph = 0; m_geo = geo_sel; end
        else m_ph++;
        @(negedge clk);
        adv = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_ph = 0; m_geo = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        dual_bit = 1'b1;
        pix_code = 16'b00_01_10_11_11_10_01_00;
        #1;
        check_all("R1");
    endtask

    // R2: no advance without strobe
    task automatic t_hold();
        step(); step(); step();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            check_all("R2");
        end
    endtask

    // R3 R4 R5 R10: arithmetic law over two full periods
    task automatic t_arith();
        geo_sel = 1'b0;
        pix_code = 16'b00_01_10_11_11_10_01_00;
        for (int k = 0; k < 24; k++) begin
            step();
            check_all("R4/R5 arith");
        end
        pix_code = 16'b10_10_01_01_00_11_10_01;
        for (int k = 0; k < 12; k++) begin
            step();
            check_all("R3 R10 mixed");
        end
    endtask

    // R8 then R6 R7: mid-period law request, then geometric periods
    task automatic t_geo();
        while (m_ph != 5) step();
        geo_sel = 1'b1;
        #1;
        check_all("R8 no early switch");
        while (m_ph != 11) begin
            step();
            check_all("R8 still arith");
        end
        step();
        check_all("R8 switched at wrap");
        for (int k = 0; k < 24; k++) begin
            step();
            check_all("R6/R7 geo");
        end
        // return to arithmetic mid-period: no effect until wrap
        while (m_ph != 3) step();
        geo_sel = 1'b0;
        for (int k = 0; k < 10; k++) begin
            step();
            check_all("R8 back to arith");
        end
    endtask

    // R9: one-bit mode, lower bit ignored
    task automatic t_mono();
        dual_bit = 1'b0;
        pix_code = 16'b01_01_10_11_00_10_01_11;
        for (int k = 0; k < 12; k++) begin
            step();
            check_all("R9 mono");
        end
        pix_code = 16'b11_00_01_10_01_11_00_10;
        #1;
        check_all("R9 mono alt");
        dual_bit = 1'b1;
        #1;
    endtask

    // R1: reset mid-period under geometric law
    task automatic t_reset_mid();
        geo_sel = 1'b1;
        while (!(m_geo && m_ph == 7)) step();
        do_reset();
        check_all("R1 mid reset");
        step();
        check_all("R1 arith after reset");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_hold();
        t_arith();
        t_geo();
        t_mono();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule